// File: doc/BRIEF.md
# Sixteen-bit programmable down-counter channel

This block is one counter/timer channel built around a 16-bit down-counter. Software programs it through a small byte-wide register port. It writes a reload value as two separate bytes, picks a mode, and then drives the channel through a command/status byte. That byte sets a software gate, starts a count, freezes the count for a two-byte read, and clears the terminal-count flag.

The counter moves on a single-cycle clock-enable pulse (`tick`). It does not decrement on every clock edge. The mode byte selects how the channel behaves:
- the output waveform: pulse, one-shot or square wave;
- whether the count runs once or reloads continuously;
- whether an external trigger input and an external gate input take part;
- whether a trigger that arrives while counting restarts the count.

A global enable input stops the channel and drops its gate.

Top module: `cnt16_channel`

## Requirements
- R1: After reset these all read 0: the reload bytes, the mode byte, the status byte and both count bytes. `wave_out`, `irq_pend` and `count_busy` are low.
- R2: Register addresses are: 0 reload low byte, 1 reload high byte, 2 mode, 3 command/status, 4 count high byte, 5 count low byte. The reload value is the concatenation of the two reload bytes and reads back unchanged.
- R3: A command write with bit 1 (trigger) loads the reload value into the counter and sets count-in-progress. This happens only while the gate bit is set. With the gate bit clear the trigger is ignored.
- R4: A command write with none of bits 1, 2 and 7 set copies bit 0 into the gate bit, so a write of 0 clears it. A write that sets any of those bits leaves the gate unchanged. Status bit 0 shows the gate.
- R5: While counting, the count drops by one on each `tick` for which the effective gate is high. The effective gate is the gate bit ANDed with `ext_gate` when mode bit 4 is set. With the effective gate low the count holds.
- R6: A `tick` at count 1 takes the count to 0 and sets interrupt-pending (`irq_pend`, status bit 4). In single-cycle mode (mode bit 2 = 0) it also clears count-in-progress (`count_busy`, status bit 3). A command write with bit 7 set clears interrupt-pending.
- R7: In continuous mode (mode bit 2 = 1) count-in-progress stays high at terminal count. The counter reloads from the reload register on the cycle after terminal count.
- R8: A command write with bit 2 set copies the live count into a holding register and sets status bit 2. While that bit is set, addresses 4 and 5 return the held value: high byte first, then low byte. Reading address 5 releases the hold, after which the live count is returned.
- R9: Mode bits [1:0] = 00 select pulse output. `wave_out` rises at terminal count and falls on the next `tick`, one count period later.
- R10: Mode bits [1:0] = 10 select square-wave output. `wave_out` toggles at every terminal count.
- R11: Mode bits [1:0] = 01 select one-shot output. `wave_out` rises when a trigger is accepted and falls at terminal count.
- R12: When mode bit 3 is set, a rising edge on `ext_trig` acts as a trigger. When mode bit 3 is clear, `ext_trig` is ignored.
- R13: A trigger that arrives while counting restarts the count from the reload value only when mode bit 5 (retrigger) is set. Otherwise it has no effect.
- R14: While `chan_en` is low the channel stops counting, clears its gate bit and drives `wave_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Global channel enable |
| tick | input | 1 | Count-clock enable, one cycle wide |
| ext_trig | input | 1 | External trigger, rising-edge sensitive |
| ext_gate | input | 1 | External gate level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (releases a held count) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| wave_out | output | 1 | Counter output waveform |
| irq_pend | output | 1 | Interrupt-pending flag |
| count_busy | output | 1 | Count-in-progress flag |

## Verification
The bench targets the terminal-count edge, where the count goes to 0 and then either stops or reloads one cycle later. An off-by-one design would show interrupt-pending a tick early or late, or would reload without ever passing through 0.

It checks that trigger-carrying command writes keep the gate bit. A decoder that copies bit 0 on every write would silently close the gate and freeze the count.

The bench also exercises the capture hold across live ticks and a low-byte release. A channel without a proper hold returns torn or moving bytes.

Retrigger and external-trigger enables are tested both on and off, so a design that restarts on every edge is caught.

// File: rtl/cnt16_pkg.sv
package cnt16_pkg;
  localparam int CW    = 16;
  localparam int BW    = 8;
  localparam int AW    = 3;
  localparam int NBYTE = CW / BW;

  localparam logic [AW-1:0] A_RLD_LO = 3'd0;
  localparam logic [AW-1:0] A_RLD_HI = 3'd1;
  localparam logic [AW-1:0] A_MODE   = 3'd2;
  localparam logic [AW-1:0] A_CMD    = 3'd3;
  localparam logic [AW-1:0] A_CNT_HI = 3'd4;
  localparam logic [AW-1:0] A_CNT_LO = 3'd5;

  localparam int B_GATE = 0;
  localparam int B_TRIG = 1;
  localparam int B_CAP  = 2;
  localparam int B_CLR  = 7;

  typedef enum logic [1:0] {
    WAVE_PULSE   = 2'b00,
    WAVE_ONESHOT = 2'b01,
    WAVE_SQUARE  = 2'b10,
    WAVE_SPARE   = 2'b11
  } wave_e;

  typedef struct packed {
    logic  retrig;
    logic  xgate_en;
    logic  xtrig_en;
    logic  cont;
    wave_e wave;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  function automatic logic [CW-1:0] dec_count(input logic [CW-1:0] c);
    return c - {{(CW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic is_terminal(input logic [CW-1:0] c);
    return c == {{(CW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [BW-1:0] pack_status(input logic gate, input logic held,
                                                input logic busy, input logic pend);
    return {3'b000, pend, busy, held, 1'b0, gate};
  endfunction
endpackage

// File: rtl/cnt16_regs.sv
module cnt16_regs
  import cnt16_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  input  logic          tc_i,
  input  logic          busy_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] reload_o,
  output mode_t         mode_o,
  output logic          gate_o,
  output logic          sw_trig_o,
  output logic          ip_o,
  output logic [BW-1:0] rdata_o
);
  logic [BW-1:0] rld_q [NBYTE];
  mode_t         mode_q;
  logic          gate_q;
  logic          ip_q;
  logic [CW-1:0] hold_q;
  logic          held_q;

  logic cmd_wr, cmd_trig, cmd_cap, cmd_clr, cmd_plain, lo_read;
  logic [CW-1:0] view;

  assign cmd_wr    = wr && (addr == A_CMD);
  assign cmd_trig  = cmd_wr && wdata[B_TRIG];
  assign cmd_cap   = cmd_wr && wdata[B_CAP];
  assign cmd_clr   = cmd_wr && wdata[B_CLR];
  assign cmd_plain = cmd_wr && !(wdata[B_TRIG] || wdata[B_CAP] || wdata[B_CLR]);
  assign lo_read   = rd && (addr == A_CNT_LO);

  genvar gi;
  generate
    for (gi = 0; gi < NBYTE; gi++) begin : g_rld
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rld_q[gi] <= '0;
        else if (wr && (addr == AW'(A_RLD_LO + gi))) rld_q[gi] <= wdata;
      end
      assign reload_o[gi*BW +: BW] = rld_q[gi];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (wr && (addr == A_MODE)) mode_q <= mode_t'(wdata[MODE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gate_q <= 1'b0;
    else if (!chan_en)  gate_q <= 1'b0;
    else if (cmd_plain) gate_q <= wdata[B_GATE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ip_q <= 1'b0;
    else if (tc_i)    ip_q <= 1'b1;
    else if (cmd_clr) ip_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      held_q <= 1'b0;
    end else if (cmd_cap) begin
      hold_q <= cnt_i;
      held_q <= 1'b1;
    end else if (lo_read) begin
      held_q <= 1'b0;
    end
  end

  assign view = held_q ? hold_q : cnt_i;

  always_comb begin
    unique case (addr)
      A_RLD_LO: rdata_o = rld_q[0];
      A_RLD_HI: rdata_o = rld_q[NBYTE-1];
      A_MODE:   rdata_o = BW'(mode_q);
      A_CMD:    rdata_o = pack_status(gate_q, held_q, busy_i, ip_q);
      A_CNT_HI: rdata_o = view[CW-1 -: BW];
      A_CNT_LO: rdata_o = view[BW-1:0];
      default:  rdata_o = '0;
    endcase
  end

  assign mode_o    = mode_q;
  assign gate_o    = gate_q;
  assign ip_o      = ip_q;
  assign sw_trig_o = cmd_trig && chan_en;

  assert_gate_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_plain && chan_en) |=> (gate_q == $past(gate_q)));
  assert_ip_on_tc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tc_i |=> ip_q);
  assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !cmd_cap) |=> $stable(hold_q));
endmodule

// File: rtl/cnt16_core.sv
module cnt16_core
  import cnt16_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          tick,
  input  logic          gate_bit,
  input  mode_t         mode,
  input  logic [CW-1:0] reload,
  input  logic          sw_trig,
  input  logic          ext_trig,
  input  logic          ext_gate,
  output logic [CW-1:0] cnt_o,
  output logic          running_o,
  output logic          tc_o,
  output logic          load_o
);
  logic [CW-1:0] cnt_q;
  logic running_q, after_tc_q, ext_q;
  logic ext_rise, trig_req, load, eff_gate, step, tc;

  assign ext_rise = mode.xtrig_en && ext_trig && !ext_q;
  assign trig_req = (sw_trig || ext_rise) && gate_bit && chan_en;
  assign load     = trig_req && (!running_q || mode.retrig);
  assign eff_gate = gate_bit && (!mode.xgate_en || ext_gate);
  assign step     = running_q && eff_gate && tick && !after_tc_q;
  assign tc       = step && is_terminal(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_trig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      running_q  <= 1'b0;
      after_tc_q <= 1'b0;
    end else if (!chan_en) begin
      running_q  <= 1'b0;
      after_tc_q <= 1'b0;
    end else if (load) begin
      cnt_q      <= reload;
      running_q  <= 1'b1;
      after_tc_q <= 1'b0;
    end else if (after_tc_q) begin
      after_tc_q <= 1'b0;
      if (running_q) cnt_q <= reload;
    end else if (step) begin
      cnt_q <= dec_count(cnt_q);
      if (tc) begin
        after_tc_q <= 1'b1;
        if (!mode.cont) running_q <= 1'b0;
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign running_o = running_q;
  assign tc_o      = tc;
  assign load_o    = load;

  assert_single_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !mode.cont && chan_en && !load) |=> !running_q);
  assert_reload_after_tc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (after_tc_q && running_q && chan_en) |=> (cnt_q == $past(reload)));
  assert_pause_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !eff_gate && !load && !after_tc_q && chan_en) |=> $stable(cnt_q));
  assert_trigger_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && chan_en) |=> (running_q && cnt_q == $past(reload)));
endmodule

// File: rtl/cnt16_wave.sv
module cnt16_wave
  import cnt16_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  chan_en,
  input  wave_e wave,
  input  logic  tick,
  input  logic  tc,
  input  logic  load,
  output logic  out_o
);
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_q <= 1'b0;
    else if (!chan_en) out_q <= 1'b0;
    else begin
      unique case (wave)
        WAVE_ONESHOT: begin
          if (load)    out_q <= 1'b1;
          else if (tc) out_q <= 1'b0;
        end
        WAVE_SQUARE: if (tc) out_q <= !out_q;
        default: begin
          if (tc)        out_q <= 1'b1;
          else if (tick) out_q <= 1'b0;
        end
      endcase
    end
  end

  assign out_o = out_q;

  assert_pulse_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && chan_en && wave == WAVE_PULSE) |=> out_q);
  assert_square_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && chan_en && wave == WAVE_SQUARE) |=> (out_q != $past(out_q)));
  assert_oneshot_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (load && chan_en && wave == WAVE_ONESHOT) |=> out_q);
  assert_disable_low_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !out_q);
endmodule

// File: rtl/cnt16_channel.sv
module cnt16_channel
  import cnt16_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          tick,
  input  logic          ext_trig,
  input  logic          ext_gate,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [BW-1:0] reg_wdata,
  output logic [BW-1:0] reg_rdata,
  output logic          wave_out,
  output logic          irq_pend,
  output logic          count_busy
);
  logic [CW-1:0] reload, cnt;
  mode_t mode;
  logic gate_bit, sw_trig, tc, load, running;

  cnt16_regs u_regs (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .wr(reg_wr), .rd(reg_rd), .addr(reg_addr), .wdata(reg_wdata),
    .tc_i(tc), .busy_i(running), .cnt_i(cnt),
    .reload_o(reload), .mode_o(mode), .gate_o(gate_bit),
    .sw_trig_o(sw_trig), .ip_o(irq_pend), .rdata_o(reg_rdata)
  );

  cnt16_core u_core (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .tick(tick),
    .gate_bit(gate_bit), .mode(mode), .reload(reload), .sw_trig(sw_trig),
    .ext_trig(ext_trig), .ext_gate(ext_gate),
    .cnt_o(cnt), .running_o(running), .tc_o(tc), .load_o(load)
  );

  cnt16_wave u_wave (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wave(mode.wave),
    .tick(tick), .tc(tc), .load(load), .out_o(wave_out)
  );

  assign count_busy = running;
endmodule

// File: tb/cnt16_channel_bench.sv
`timescale 1ns/1ps
module cnt16_channel_bench;
  logic clk = 1'b0, rst_n = 1'b0, chan_en = 1'b1, tick = 1'b0;
  logic ext_trig = 1'b0, ext_gate = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic wave_out, irq_pend, count_busy;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = !clk;

  cnt16_channel u_cnt16_channel (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .tick(tick),
    .ext_trig(ext_trig), .ext_gate(ext_gate), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wave_out(wave_out), .irq_pend(irq_pend), .count_busy(count_busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic read_count(output logic [15:0] v);
    logic [7:0] h, l;
    rd(3'd4, h); rd(3'd5, l); v = {h, l};
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
  endtask

  task automatic set_reload(input logic [15:0] v);
    wr(3'd0, v[7:0]); wr(3'd1, v[15:8]);
  endtask

  task automatic restart_channel();
    @(negedge clk); chan_en = 1'b0;
    @(negedge clk); chan_en = 1'b1;
    wr(3'd3, 8'h01);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v); chk(v == 8'h00, "R1 register reads zero", v, 0);
    end
    chk({wave_out, irq_pend, count_busy} == 3'b000, "R1 outputs low",
        {wave_out, irq_pend, count_busy}, 0);
  endtask

  task automatic t_reload();
    logic [7:0] l, h;
    set_reload(16'h1234);
    rd(3'd0, l); rd(3'd1, h);
    chk({h, l} == 16'h1234, "R2 reload readback", {h, l}, 16'h1234);
    set_reload(16'h0005);
  endtask

  task automatic t_trigger_gate();
    logic [7:0] s; logic [15:0] c;
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h02);
    chk(!count_busy, "R3 trigger ignored with gate clear", count_busy, 0);
    wr(3'd3, 8'h01);
    wr(3'd3, 8'h02);
    rd(3'd3, s);
    chk(s[3] == 1'b1, "R3 busy after trigger", s[3], 1);
    chk(s[0] == 1'b1, "R4 gate kept by trigger write", s[0], 1);
    read_count(c);
    chk(c == 16'h0005, "R3 count loaded", c, 5);
  endtask

  task automatic t_count_pause();
    logic [15:0] c; logic [7:0] s;
    ticks(3); read_count(c);
    chk(c == 16'h0002, "R5 decrement per tick", c, 2);
    wr(3'd3, 8'h00);
    rd(3'd3, s);
    chk(s[0] == 1'b0, "R4 write of zero clears gate", s[0], 0);
    ticks(2); read_count(c);
    chk(c == 16'h0002, "R5 holds with gate low", c, 2);
    wr(3'd3, 8'h01);
  endtask

  task automatic t_tc_single();
    logic [15:0] c; logic [7:0] s;
    ticks(2);
    chk(irq_pend && !count_busy, "R6 pending set and busy cleared",
        {irq_pend, count_busy}, 2'b10);
    chk(wave_out, "R9 pulse high at terminal count", wave_out, 1);
    read_count(c);
    chk(c == 16'h0000, "R6 count at zero", c, 0);
    ticks(1);
    chk(!wave_out, "R9 pulse low after one period", wave_out, 0);
    wr(3'd3, 8'h80);
    rd(3'd3, s);
    chk(!irq_pend && s[0], "R6 clear command keeps gate", {irq_pend, s[0]}, 2'b01);
  endtask

  task automatic t_capture();
    logic [7:0] h, l, l2, s;
    set_reload(16'h0203);
    wr(3'd3, 8'h02);
    ticks(1);
    wr(3'd3, 8'h04);
    rd(3'd3, s);
    chk(s[2], "R8 held flag set", s[2], 1);
    ticks(2);
    rd(3'd4, h); rd(3'd5, l); rd(3'd5, l2);
    chk({h, l} == 16'h0202, "R8 held value", {h, l}, 16'h0202);
    chk(l2 == 8'h00, "R8 live value after release", l2, 0);
  endtask

  task automatic t_disable();
    logic [7:0] s;
    @(negedge clk); chan_en = 1'b0;
    @(negedge clk); chan_en = 1'b1;
    rd(3'd3, s);
    chk(!count_busy && !s[0] && !wave_out, "R14 disable stops and clears gate",
        {count_busy, s[0], wave_out}, 0);
    wr(3'd3, 8'h01);
  endtask

  task automatic t_continuous_square();
    logic [15:0] c;
    set_reload(16'h0003);
    wr(3'd2, 8'h06);
    wr(3'd3, 8'h02);
    ticks(3);
    chk(wave_out, "R10 square toggles high", wave_out, 1);
    chk(count_busy && irq_pend, "R7 busy stays in continuous",
        {count_busy, irq_pend}, 2'b11);
    read_count(c);
    chk(c == 16'h0003, "R7 reload after terminal count", c, 3);
    ticks(3);
    chk(!wave_out, "R10 square toggles low", wave_out, 0);
    wr(3'd3, 8'h80);
  endtask

  task automatic t_oneshot();
    set_reload(16'h0002);
    wr(3'd2, 8'h01);
    wr(3'd3, 8'h02);
    chk(wave_out, "R11 one-shot high on trigger", wave_out, 1);
    ticks(1);
    chk(wave_out, "R11 one-shot held mid-count", wave_out, 1);
    ticks(1);
    chk(!wave_out && !count_busy, "R11 one-shot low at terminal count",
        {wave_out, count_busy}, 0);
  endtask

  task automatic t_ext_trigger();
    logic [15:0] c;
    ext_pulse();
    chk(!count_busy, "R12 edge ignored without enable", count_busy, 0);
    set_reload(16'h0004);
    wr(3'd2, 8'h09);
    ext_pulse();
    read_count(c);
    chk(count_busy && c == 16'h0004, "R12 external edge starts", c, 4);
    ticks(1); ext_pulse(); read_count(c);
    chk(c == 16'h0003, "R13 no restart without retrigger", c, 3);
    wr(3'd2, 8'h29);
    ext_pulse(); read_count(c);
    chk(c == 16'h0004, "R13 retrigger restarts", c, 4);
  endtask

  task automatic t_ext_gate();
    logic [15:0] c;
    set_reload(16'h0005);
    wr(3'd2, 8'h10);
    ext_gate = 1'b0;
    wr(3'd3, 8'h02);
    ticks(1); read_count(c);
    chk(count_busy && c == 16'h0005, "R5 external gate low holds", c, 5);
    ext_gate = 1'b1;
    ticks(1); read_count(c);
    chk(c == 16'h0004, "R5 external gate high counts", c, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reload();
    t_trigger_gate();
    t_count_pause();
    t_tc_single();
    t_capture();
    t_disable();
    t_continuous_square();
    restart_channel();
    t_oneshot();
    t_ext_trigger();
    restart_channel();
    t_ext_gate();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule